// File: doc/BRIEF.md
# Byte-Moving DMA Engine with Swapped Channel Contexts

This engine serves many peripheral channels but keeps only one channel's working context inside the block. Every channel owns a four-word descriptor in system RAM: a source address, a destination address, a remaining byte count and a mode word. The descriptor array sits at a programmable base pointer, one 16-byte slot per channel.

A peripheral raises its trigger line when it wants one byte moved. The engine picks the lowest-numbered pending channel. If that channel is not the one held inside the block, the engine writes the held context back to its RAM slot, reads the new channel's four words, and then moves a single byte. A channel that is already held skips the swap entirely. When a channel's count runs out, the engine raises that channel's done flag and disables it. An access counter exposes the number of completed memory accesses, so the cost of the context swapping can be measured directly.

Software programs the base pointer and the channel enable mask through a small register port. The single memory master port uses a request/acknowledge handshake.

Top module: `swapctx_dma`

## Requirements
- R1: After reset, no channel context is held, all done flags are 0, the access counter is 0, and no memory request is raised.
- R2: Writing the register port with cfg_sel=0 sets the base pointer. The descriptor of channel n occupies base+16n. Its words are, at offsets +0, +4, +8 and +12: source address, destination address, remaining count, mode. All memory addresses issued are word aligned.
- R3: Servicing a channel that is not held first writes the four held words to the held channel's slot, in offset order, when a context is held. It then reads the four words of the new channel. With no context held, only the four reads occur.
- R4: Servicing the channel that is already held issues no descriptor access, only the two data accesses.
- R5: Each service moves one byte. The engine reads the word at the source address with its two low bits cleared and takes byte lane source[1:0] (lane k is bits 8k+7:8k). It then writes the word at the destination address with its two low bits cleared, with the byte replicated on all lanes and only byte-enable bit destination[1:0] set. Descriptor write-backs use all four byte enables.
- R6: Mode bit 0 set makes the source address advance by 1 per byte, and mode bit 1 set does the same for the destination address. A clear bit keeps that address fixed. The count decreases by 1 per byte.
- R7: When the count reaches 0, the channel's done bit is set and its enable bit cleared, and later triggers on it are ignored. A channel whose loaded count is already 0 completes in the same way, with no data access.
- R8: When several channels are pending, the lowest channel number is served first, one channel at a time.
- R9: A trigger on a disabled channel is ignored and not remembered. Enabling the channel later does not start a service.
- R10: Writing the register port with cfg_sel=1 loads the enable mask (bit n enables channel n). A bit that goes from 0 to 1 clears that channel's done bit. If that channel is the held one, the held context is discarded without a write-back.
- R11: Every memory request holds its address, direction and data until mem_ack. acc_count increments by one for each acknowledged access and does not change otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register port write strobe |
| cfg_sel | input | 1 | 0: base pointer, 1: enable mask |
| cfg_wdata | input | 32 | Register port write data |
| trig | input | NCH | Per-channel one-byte transfer request pulses |
| done | output | NCH | Per-channel completion flags |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write access |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completion |
| acc_count | output | CNT_W | Completed memory access count |

## Verification
The hardest situation to reach is a swap whose write-back lands in RAM while another channel is loaded, because the written-back words become visible only through memory. The bench drives a channel to completion while it is held, triggers a different channel, and then reads the old slot to find the advanced addresses and zero count. The access counter delta tells a swap, a first load and a resident hit apart. A second hard case is discarding a held context when its channel is re-enabled: the bench rewrites the descriptor, re-enables the channel and expects a load-only cost with data taken from the new descriptor. A sweep over all twelve channels at a moved base pointer checks the slot arithmetic.

// File: rtl/swapctx_dma_pkg.sv
// Shared definitions for the swapped-context DMA engine.
// Assumes a 32-bit memory bus with byte addresses and four byte lanes.
package swapctx_dma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a pending channel
        ST_WB,     // writing the held context back to RAM
        ST_LD,     // reading the new context from RAM
        ST_RD,     // reading the source word
        ST_WR      // writing the destination byte
    } dma_state_e;

    localparam int ADDR_W    = 32;
    localparam int WORD_W    = 32;
    localparam int CTX_WORDS = 4;
    localparam int SLOT_SH   = 4;   // log2 of bytes per descriptor slot

    // word positions inside a descriptor slot
    localparam logic [1:0] W_SRC = 2'd0;
    localparam logic [1:0] W_DST = 2'd1;
    localparam logic [1:0] W_LEN = 2'd2;
    localparam logic [1:0] W_CFG = 2'd3;
endpackage

// File: rtl/swapctx_dma_arb.sv
// Fixed-priority picker: the lowest set request bit wins.
// Assumes NCH >= 1; purely combinational.
module swapctx_dma_arb #(
    parameter int NCH  = 12,
    parameter int CH_W = 4
) (
    input  logic [NCH-1:0]  req,
    output logic            gnt_vld,
    output logic [CH_W-1:0] gnt_idx
);
    // scan from the top so the lowest index is assigned last
    always_comb begin
        gnt_vld = 1'b0;
        gnt_idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt_vld = 1'b1;
                gnt_idx = CH_W'(i);
            end
        end
    end
endmodule

// File: rtl/swapctx_dma_ctx.sv
// Holds the one resident channel context (source, destination, count, mode).
// Words load one at a time from RAM; a beat step advances the addresses and
// decrements the count. Assumes load and step never coincide.
module swapctx_dma_ctx
    import swapctx_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [1:0]        ld_sel,
    input  logic [WORD_W-1:0] ld_data,
    input  logic              step_en,
    input  logic [1:0]        rd_sel,
    output logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] src,
    output logic [WORD_W-1:0] dst,
    output logic [WORD_W-1:0] len,
    output logic [WORD_W-1:0] cfg
);
    // context words: reset, per-word load, or one beat of progress
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src <= '0;
            dst <= '0;
            len <= '0;
            cfg <= '0;
        end else if (ld_en) begin
            case (ld_sel)
                W_SRC:   src <= ld_data;
                W_DST:   dst <= ld_data;
                W_LEN:   len <= ld_data;
                default: cfg <= ld_data;
            endcase
        end else if (step_en) begin
            if (cfg[0]) src <= src + 1'b1;
            if (cfg[1]) dst <= dst + 1'b1;
            len <= len - 1'b1;
        end
    end

    // word selected for write-back
    always_comb begin
        case (rd_sel)
            W_SRC:   rd_data = src;
            W_DST:   rd_data = dst;
            W_LEN:   rd_data = len;
            default: rd_data = cfg;
        endcase
    end
endmodule

// File: rtl/swapctx_dma_cnt.sv
// Free-running access counter; wraps at its width.
module swapctx_dma_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    // count one per completed access
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + 1'b1;
    end
endmodule

// File: rtl/swapctx_dma.sv
// Multi-channel byte DMA that keeps a single channel context on chip and
// swaps contexts through RAM-resident descriptors (base + 16*channel).
// Assumes NCH <= 32 and a memory that acknowledges each request once.
module swapctx_dma
    import swapctx_dma_pkg::*;
#(
    parameter int NCH   = 12,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic [NCH-1:0]    trig,
    output logic [NCH-1:0]    done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_be,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    output logic [CNT_W-1:0]  acc_count
);
    localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int OFS_PAD = ADDR_W - CH_W - SLOT_SH;
    localparam logic [NCH-1:0] ONE_CH = {{(NCH-1){1'b0}}, 1'b1};

    dma_state_e        st;
    logic [1:0]        idx;
    logic [CH_W-1:0]   tgt, res_ch, gnt_idx;
    logic              res_vld, gnt_vld;
    logic [31:0]       base_q;
    logic [NCH-1:0]    en_q, pend_q, done_q;
    logic [7:0]        byte_q;
    logic [WORD_W-1:0] c_src, c_dst, c_len, c_cfg, c_word;

    // descriptor word address for a channel and word position
    function automatic logic [31:0] slot_addr(input logic [31:0] b,
                                              input logic [CH_W-1:0] ch,
                                              input logic [1:0] w);
        return b + {{OFS_PAD{1'b0}}, ch, w, 2'b00};
    endfunction

    logic           en_wr, res_drop, res_live, acc, fin, grant;
    logic [NCH-1:0] en_rise, fin_mask, clr_mask;
    logic [31:0]    rd_shift;

    // event decode shared by the flag and state processes
    always_comb begin
        en_wr    = cfg_we && cfg_sel;
        en_rise  = en_wr ? (cfg_wdata[NCH-1:0] & ~en_q) : '0;
        res_drop = res_vld && en_rise[res_ch];
        res_live = res_vld && !res_drop;
        acc      = mem_req && mem_ack;
        grant    = (st == ST_IDLE) && gnt_vld;
        fin      = ((st == ST_WR) && mem_ack && (c_len == 32'd1)) ||
                   ((st == ST_LD) && mem_ack && (idx == 2'd3) && (c_len == '0));
        fin_mask = fin ? (ONE_CH << tgt) : '0;
        clr_mask = grant ? (ONE_CH << gnt_idx) : '0;
        rd_shift = mem_rdata >> {c_src[1:0], 3'b000};
    end

    swapctx_dma_arb #(.NCH(NCH), .CH_W(CH_W)) u_arb (
        .req     (pend_q & en_q),
        .gnt_vld (gnt_vld),
        .gnt_idx (gnt_idx)
    );

    swapctx_dma_ctx u_ctx (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   ((st == ST_LD) && mem_ack),
        .ld_sel  (idx),
        .ld_data (mem_rdata),
        .step_en ((st == ST_WR) && mem_ack),
        .rd_sel  (idx),
        .rd_data (c_word),
        .src     (c_src),
        .dst     (c_dst),
        .len     (c_len),
        .cfg     (c_cfg)
    );

    swapctx_dma_cnt #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (acc),
        .count (acc_count)
    );

    // software registers: base pointer and enable mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            en_q   <= '0;
        end else begin
            if (cfg_we && !cfg_sel) base_q <= cfg_wdata;
            if (en_wr)              en_q   <= cfg_wdata[NCH-1:0];
            else                    en_q   <= en_q & ~fin_mask;
        end
    end

    // pending requests (enabled channels only) and sticky done flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            done_q <= '0;
        end else begin
            pend_q <= ((pend_q & ~clr_mask) | trig) & en_q & ~fin_mask;
            done_q <= (done_q & ~en_rise) | fin_mask;
        end
    end

    // sequencer: swap contexts as needed, then move one byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            idx     <= '0;
            tgt     <= '0;
            res_ch  <= '0;
            res_vld <= 1'b0;
            byte_q  <= '0;
        end else begin
            if (res_drop) res_vld <= 1'b0;
            case (st)
                ST_IDLE: if (gnt_vld) begin
                    tgt <= gnt_idx;
                    idx <= '0;
                    if (res_live && (res_ch == gnt_idx)) st <= ST_RD;
                    else if (res_live)                  st <= ST_WB;
                    else                                st <= ST_LD;
                end
                ST_WB: if (mem_ack) begin
                    idx <= idx + 1'b1;
                    if (idx == 2'd3) begin
                        st      <= ST_LD;
                        res_vld <= 1'b0;
                    end
                end
                ST_LD: if (mem_ack) begin
                    idx <= idx + 1'b1;
                    if (idx == 2'd3) begin
                        res_vld <= 1'b1;
                        res_ch  <= tgt;
                        st      <= (c_len == '0) ? ST_IDLE : ST_RD;
                    end
                end
                ST_RD: if (mem_ack) begin
                    byte_q <= rd_shift[7:0];
                    st     <= ST_WR;
                end
                ST_WR: if (mem_ack) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // memory master drive, decoded from the sequencer state
    always_comb begin
        mem_req   = (st != ST_IDLE);
        mem_we    = (st == ST_WB) || (st == ST_WR);
        mem_addr  = '0;
        mem_wdata = '0;
        mem_be    = 4'hF;
        case (st)
            ST_WB: begin
                mem_addr  = slot_addr(base_q, res_ch, idx);
                mem_wdata = c_word;
            end
            ST_LD: mem_addr = slot_addr(base_q, tgt, idx);
            ST_RD: mem_addr = {c_src[31:2], 2'b00};
            ST_WR: begin
                mem_addr  = {c_dst[31:2], 2'b00};
                mem_wdata = {4{byte_q}};
                mem_be    = 4'b0001 << c_dst[1:0];
            end
            default: ;
        endcase
    end

    assign done = done_q;
endmodule

// File: rtl/swapctx_dma_chk.sv
// Port-level protocol checks for swapctx_dma, attached with bind.
module swapctx_dma_chk #(
    parameter int NCH   = 12,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_req,
    input logic             mem_we,
    input logic [31:0]      mem_addr,
    input logic [3:0]       mem_be,
    input logic             mem_ack,
    input logic [NCH-1:0]   done,
    input logic [CNT_W-1:0] acc_count
);
    // R11: a request stays put until acknowledged
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R11: counter moves only on an acknowledged access
    a_r11_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && mem_ack) |=> $stable(acc_count));

    // R5: writes use one byte lane or a full word
    a_r5_write_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> (mem_be == 4'hF) || ($countones(mem_be) == 1));

    // R2: all issued addresses are word aligned
    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R7: a done flag only rises right after a completed access
    a_r7_done_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        ((done & ~$past(done)) != '0) |-> $past(mem_req && mem_ack));

    // R8: channels finish one at a time
    a_r8_one_finish: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(done & ~$past(done)) <= 1);
endmodule

bind swapctx_dma swapctx_dma_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_ack   (mem_ack),
    .done      (done),
    .acc_count (acc_count)
);

// File: tb/swapctx_dma_tb.sv
`timescale 1ns/1ps
module swapctx_dma_tb;
    localparam int NCH   = 12;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [NCH-1:0] trig = '0;
    logic [NCH-1:0] done;
    logic mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0] mem_be;
    logic [CNT_W-1:0] acc_count;

    int total = 0;
    int bad = 0;
    logic [31:0] mem [0:255];
    logic [NCH-1:0] en_model = '0;

    always #2 clk = ~clk;

    swapctx_dma #(.NCH(NCH), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .trig(trig), .done(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .acc_count(acc_count)
    );

    // memory model: acknowledges each request one cycle later
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr[9:2]];
            if (mem_we)
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        end else begin
            mem_ack <= 1'b0;
        end
    end

    function automatic logic [7:0] pat(input int a);
        return 8'(a * 7 + 3);
    endfunction

    function automatic logic [7:0] rd8(input int a);
        logic [31:0] w;
        w = mem[a[9:2]];
        return w[8*a[1:0] +: 8];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_desc(input int base, input int c, input int s, input int d,
                            input int n, input int m);
        int w;
        w = (base + 16 * c) >> 2;
        mem[w]     = 32'(s);
        mem[w + 1] = 32'(d);
        mem[w + 2] = 32'(n);
        mem[w + 3] = 32'(m);
    endtask

    task automatic pulse(input logic [NCH-1:0] m);
        @(negedge clk);
        trig = m;
        @(negedge clk);
        trig = '0;
        repeat (40) @(negedge clk);
    endtask

    logic [CNT_W-1:0] a0;

    initial begin
        for (int w = 0; w < 256; w++)
            mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(done == '0, "R1 done", 32'(done), 0);
        chk(acc_count == '0, "R1 count", 32'(acc_count), 0);
        chk(mem_req == 1'b0, "R1 req", 32'(mem_req), 0);
        rst_n = 1'b1;

        wr_reg(1'b0, 32'h100);
        en_model = '1;
        wr_reg(1'b1, 32'(en_model));

        // first service with nothing held: R3 load-only, R5 lanes
        set_desc(32'h100, 0, 32'h201, 32'h302, 3, 3);
        a0 = acc_count;
        pulse(12'h001);
        chk(acc_count - a0 == 6, "R3 first load cost", 32'(acc_count - a0), 6);
        chk(rd8(32'h302) == pat(32'h201), "R5 byte lane", rd8(32'h302), pat(32'h201));
        // R4 resident hits, R6 increments
        for (int k = 1; k < 3; k++) begin
            a0 = acc_count;
            pulse(12'h001);
            chk(acc_count - a0 == 2, "R4 hit cost", 32'(acc_count - a0), 2);
            chk(rd8(32'h302 + k) == pat(32'h201 + k), "R6 both advance",
                rd8(32'h302 + k), pat(32'h201 + k));
        end
        chk(done[0] == 1'b1, "R7 done ch0", 32'(done), 1);
        chk(mem[(32'h100 + 8) >> 2] == 3, "R4 no write-back on hit",
            mem[(32'h100 + 8) >> 2], 3);
        en_model[0] = 1'b0;
        a0 = acc_count;
        pulse(12'h001);
        chk(acc_count == a0, "R7 finished channel ignores trigger", 32'(acc_count), 32'(a0));

        // swap to ch1 (source advances, destination fixed): R3 write-back
        set_desc(32'h100, 1, 32'h210, 32'h310, 2, 1);
        a0 = acc_count;
        pulse(12'h002);
        chk(acc_count - a0 == 10, "R3 swap cost", 32'(acc_count - a0), 10);
        chk(mem[32'h100 >> 2] == 32'h204, "R3 wb src", mem[32'h100 >> 2], 32'h204);
        chk(mem[32'h104 >> 2] == 32'h305, "R3 wb dst", mem[32'h104 >> 2], 32'h305);
        chk(mem[32'h108 >> 2] == 0, "R3 wb len", mem[32'h108 >> 2], 0);
        chk(mem[32'h10C >> 2] == 3, "R3 wb cfg", mem[32'h10C >> 2], 3);
        pulse(12'h002);
        chk(rd8(32'h310) == pat(32'h211), "R6 fixed dst", rd8(32'h310), pat(32'h211));
        chk(done[1] == 1'b1, "R7 done ch1", 32'(done), 2);
        en_model[1] = 1'b0;

        // ch2: source fixed, destination advances
        set_desc(32'h100, 2, 32'h220, 32'h320, 2, 2);
        pulse(12'h004);
        pulse(12'h004);
        chk(rd8(32'h320) == pat(32'h220), "R6 fixed src 0", rd8(32'h320), pat(32'h220));
        chk(rd8(32'h321) == pat(32'h220), "R6 fixed src 1", rd8(32'h321), pat(32'h220));
        en_model[2] = 1'b0;

        // ch3: count 0 at load completes without data access
        set_desc(32'h100, 3, 32'h230, 32'h330, 0, 3);
        a0 = acc_count;
        pulse(12'h008);
        chk(acc_count - a0 == 8, "R7 zero count cost", 32'(acc_count - a0), 8);
        chk(done[3] == 1'b1, "R7 zero count done", 32'(done), 8);
        chk(rd8(32'h330) == pat(32'h330), "R7 zero count no write", rd8(32'h330), pat(32'h330));
        en_model[3] = 1'b0;

        // R8: simultaneous ch4 and ch5, lower wins
        set_desc(32'h100, 4, 32'h240, 32'h340, 1, 3);
        set_desc(32'h100, 5, 32'h241, 32'h341, 1, 3);
        a0 = acc_count;
        @(negedge clk);
        trig = 12'h030;
        @(negedge clk);
        trig = '0;
        for (int t = 0; t < 80; t++) begin
            if (done[5:4] != 2'b00) break;
            @(negedge clk);
        end
        chk(done[5:4] == 2'b01, "R8 lowest first", 32'(done[5:4]), 1);
        repeat (40) @(negedge clk);
        chk(acc_count - a0 == 20, "R8 both served", 32'(acc_count - a0), 20);
        chk(rd8(32'h341) == pat(32'h241), "R8 second data", rd8(32'h341), pat(32'h241));
        en_model[5:4] = 2'b00;

        // R9: disabled trigger ignored and forgotten
        en_model[6] = 1'b0;
        wr_reg(1'b1, 32'(en_model));
        a0 = acc_count;
        pulse(12'h040);
        chk(acc_count == a0, "R9 disabled ignored", 32'(acc_count), 32'(a0));
        en_model[6] = 1'b1;
        wr_reg(1'b1, 32'(en_model));
        repeat (40) @(negedge clk);
        chk(acc_count == a0, "R9 not remembered", 32'(acc_count), 32'(a0));
        chk(done[6] == 1'b0, "R9 no done", 32'(done), 0);

        // R10: re-enable held ch5, context discarded, new descriptor used
        set_desc(32'h100, 5, 32'h250, 32'h350, 1, 3);
        en_model[5] = 1'b1;
        wr_reg(1'b1, 32'(en_model));
        chk(done[5] == 1'b0, "R10 done cleared", 32'(done[5]), 0);
        a0 = acc_count;
        pulse(12'h020);
        chk(acc_count - a0 == 6, "R10 load without write-back", 32'(acc_count - a0), 6);
        chk(rd8(32'h350) == pat(32'h250), "R10 new descriptor", rd8(32'h350), pat(32'h250));

        // R2: sweep all channels at a moved base
        wr_reg(1'b0, 32'h140);
        for (int c = 0; c < NCH; c++)
            set_desc(32'h140, c, 32'h200 + 16*c + (c % 4), 32'h300 + 16*c + ((c+1) % 4), 2, 3);
        en_model = '1;
        wr_reg(1'b1, 32'(en_model));
        for (int c = 0; c < NCH; c++) begin
            int s, d;
            s = 32'h200 + 16*c + (c % 4);
            d = 32'h300 + 16*c + ((c+1) % 4);
            a0 = acc_count;
            pulse(NCH'(1) << c);
            pulse(NCH'(1) << c);
            chk(acc_count - a0 == ((c == 0) ? 8 : 12), "R2 sweep cost",
                32'(acc_count - a0), (c == 0) ? 8 : 12);
            chk(rd8(d) == pat(s) && rd8(d+1) == pat(s+1), "R2 sweep data",
                {rd8(d+1), rd8(d)}, {pat(s+1), pat(s)});
            chk(done[c] == 1'b1, "R2 sweep done", 32'(done), 32'(1) << c);
        end
        chk(mem[(32'h140 + 160) >> 2] == 32'h200 + 160 + 2 + 2, "R2 slot 10 wb src",
            mem[(32'h140 + 160) >> 2], 32'h200 + 164);
        chk(mem[(32'h140 + 168) >> 2] == 0, "R2 slot 10 wb len",
            mem[(32'h140 + 168) >> 2], 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule